// File: doc/BRIEF.md
# SD Command Frame Serializer

This block builds the 48-bit command frame that a host sends to an SD card on the CMD line, and drives the SD clock while it shifts the frame out. A single start strobe captures a 6-bit command index and a 32-bit argument. The frame is then sent most significant bit first. Its CRC7 is worked out serially from the same bits as they leave, so no separate CRC pass is needed. The CRC is then sent ahead of the end bit.

Each frame bit takes two phases of `PHASE_LEN` system clocks each. In the first phase the SD clock is low and the new bit is placed on CMD. In the second phase the SD clock is high and the bit is held, so the card samples it on the rising edge. A sequencer on the host side issues one command at a time and waits for `busy_o` to drop before it issues the next. Response reception is handled elsewhere.

Top module: `sd_cmd_framer`

## Requirements
- R1: After reset, busy_o is 0, cmdOe_o is 0, sdClk_o is 0 and cmdData_o is 1. Whenever cmdOe_o is 0, cmdData_o rests at 1 and sdClk_o at 0.
- R2: The first two frame bits are 0 (start bit) and then 1 (host direction bit). They are followed by the six index bits, MSB first.
- R3: The 32 argument bits follow the index, MSB first. The argument captured on the accepted strobe is sent.
- R4: The CRC register is 7 bits wide. It is cleared at each accepted strobe and updated once for each of the first 40 frame bits. On each update it shifts left by one, and it is XORed with 0x09 when its old bit 6 XOR the data bit is 1. Frame bits 40..46 carry the CRC, MSB first, and bit 47 is the end bit 1. For example, index 0 with argument 0 ends in byte 0x95, and index 8 with argument 0x1AA ends in byte 0x87.
- R5: Each frame bit occupies 2*PHASE_LEN cycles. During the first PHASE_LEN cycles sdClk_o is 0, and during the next PHASE_LEN cycles sdClk_o is 1. cmdData_o does not change inside one bit.
- R6: cmdOe_o is 1 for exactly the 48-bit frame and drops in the cycle after the end bit's high phase.
- R7: busy_o rises in the cycle after an accepted strobe and stays high for exactly 96*PHASE_LEN cycles.
- R8: A start strobe that arrives while busy_o is 1 is ignored. It does not change the frame in flight, and no frame is queued after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, accepted when not busy |
| cmdIdx_i | input | 6 | Command index, captured on the accepted strobe |
| cmdArg_i | input | 32 | Command argument, captured on the accepted strobe |
| sdClk_o | output | 1 | SD clock |
| cmdData_o | output | 1 | CMD line data |
| cmdOe_o | output | 1 | CMD line output enable |
| busy_o | output | 1 | High while a frame is being sent |

## Verification
The assertions assume that reset has been applied before the first strobe. They also assume that index and argument only need to be valid in the cycle in which the strobe is accepted. Beyond that, they depend on nothing the host does, because the strobe is ignored while busy. The stimulus changes inputs only on falling clock edges and holds each strobe for exactly one cycle. It also drives a deliberate second strobe, carrying a different index, into the middle of one frame. This tests the ignore rule without leaving that assumption.

// File: rtl/sd_frame_pkg.sv
package sd_frame_pkg;
  localparam int CMD_W    = 6;
  localparam int ARG_W    = 32;
  localparam int CRC_W    = 7;
  localparam int HDR_BITS = 2 + CMD_W + ARG_W;
  localparam int FRAME_BITS = HDR_BITS + CRC_W + 1;
  localparam int CNT_W    = $clog2(FRAME_BITS);

  typedef struct packed {
    logic load;     // capture index/argument, clear CRC
    logic step;     // move on to the next frame bit
    logic crcStep;  // bit leaving belongs to the CRC-covered header
    logic crcLoad;  // last header bit leaving: insert CRC and end bit
  } frameStrobe_t;
endpackage

// File: rtl/sd_frame_ctrl.sv
module sd_frame_ctrl
  import sd_frame_pkg::*;
#(
  parameter int PHASE_LEN = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  output frameStrobe_t strb_o,
  output logic         sdClk_o,
  output logic         busy_o
);
  localparam int PW = (PHASE_LEN > 1) ? $clog2(PHASE_LEN) : 1;
  localparam logic [PW-1:0]    PHASE_LAST = PW'(PHASE_LEN - 1);
  localparam logic [CNT_W-1:0] BIT_LAST   = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] HDR_LAST   = CNT_W'(HDR_BITS - 1);

  typedef enum logic [1:0] {IDLE, CLK_LO, CLK_HI} ctrlState_t;

  ctrlState_t      state;
  logic [PW-1:0]   phaseCnt;
  logic [CNT_W-1:0] bitCnt;
  logic            phaseEnd;

  assign phaseEnd = (phaseCnt == PHASE_LAST);

  always_comb begin
    strb_o.load    = (state == IDLE) && start_i;
    strb_o.step    = (state == CLK_HI) && phaseEnd && (bitCnt != BIT_LAST);
    strb_o.crcStep = strb_o.step && (bitCnt <= HDR_LAST);
    strb_o.crcLoad = strb_o.step && (bitCnt == HDR_LAST);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state    <= IDLE;
      phaseCnt <= '0;
      bitCnt   <= '0;
    end else begin
      case (state)
        IDLE: if (start_i) begin
          state    <= CLK_LO;
          phaseCnt <= '0;
          bitCnt   <= '0;
        end
        CLK_LO: begin
          if (phaseEnd) begin
            state    <= CLK_HI;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        CLK_HI: begin
          if (phaseEnd) begin
            phaseCnt <= '0;
            if (bitCnt == BIT_LAST) begin
              state <= IDLE;
            end else begin
              state  <= CLK_LO;
              bitCnt <= bitCnt + 1'b1;
            end
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  assign busy_o  = (state != IDLE);
  assign sdClk_o = (state == CLK_HI);

  // R7
  bit_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bitCnt <= BIT_LAST);

  // R6
  frame_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(bitCnt) == BIT_LAST);

  // R8
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && state == CLK_LO) |=> busy_o);
endmodule

// File: rtl/sd_frame_dp.sv
module sd_frame_dp
  import sd_frame_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  frameStrobe_t     strb_i,
  input  logic             drive_i,
  input  logic [CMD_W-1:0] cmdIdx_i,
  input  logic [ARG_W-1:0] cmdArg_i,
  output logic             cmdData_o
);
  logic [HDR_BITS-1:0] shiftReg;
  logic [CRC_W-1:0]    crcReg;
  logic [CRC_W-1:0]    crcNext;
  logic                feedback;

  always_comb begin
    feedback = crcReg[CRC_W-1] ^ shiftReg[HDR_BITS-1];
    crcNext  = {crcReg[CRC_W-2:0], 1'b0} ^ (feedback ? 7'h09 : 7'h00);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      shiftReg <= '0;
      crcReg   <= '0;
    end else if (strb_i.load) begin
      shiftReg <= {2'b01, cmdIdx_i, cmdArg_i};
      crcReg   <= '0;
    end else if (strb_i.step) begin
      shiftReg <= shiftReg << 1;
      if (strb_i.crcStep) crcReg <= crcNext;
      if (strb_i.crcLoad) shiftReg[HDR_BITS-1 -: CRC_W+1] <= {crcNext, 1'b1};
    end
  end

  assign cmdData_o = drive_i ? shiftReg[HDR_BITS-1] : 1'b1;

  // R2
  load_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_i.load |=> shiftReg[HDR_BITS-1 -: 2] == 2'b01);

  // R4
  end_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_i.crcLoad |=> shiftReg[HDR_BITS-CRC_W-1]);
endmodule

// File: rtl/sd_cmd_framer.sv
module sd_cmd_framer
  import sd_frame_pkg::*;
#(
  parameter int PHASE_LEN = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [5:0]  cmdIdx_i,
  input  logic [31:0] cmdArg_i,
  output logic        sdClk_o,
  output logic        cmdData_o,
  output logic        cmdOe_o,
  output logic        busy_o
);
  frameStrobe_t strb;
  logic         busy;
  logic         sdClk;
  logic         cmdData;

  sd_frame_ctrl #(.PHASE_LEN(PHASE_LEN)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .strb_o  (strb),
    .sdClk_o (sdClk),
    .busy_o  (busy)
  );

  sd_frame_dp u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strb_i    (strb),
    .drive_i   (busy),
    .cmdIdx_i  (cmdIdx_i),
    .cmdArg_i  (cmdArg_i),
    .cmdData_o (cmdData)
  );

  assign sdClk_o   = sdClk;
  assign cmdData_o = cmdData;
  assign cmdOe_o   = busy;
  assign busy_o    = busy;

  // R5
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdClk) |-> $stable(cmdData));

  // R1
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (cmdData && !sdClk));
endmodule

// File: tb/sd_cmd_framer_test.sv
module sd_cmd_framer_test;
  localparam int P = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  idx = '0;
  logic [31:0] arg = '0;
  logic        sdClk, cmdData, cmdOe, busy;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  sd_cmd_framer #(.PHASE_LEN(P)) uut (
    .clk_i(clk), .rst_ni(rstN), .start_i(start), .cmdIdx_i(idx), .cmdArg_i(arg),
    .sdClk_o(sdClk), .cmdData_o(cmdData), .cmdOe_o(cmdOe), .busy_o(busy)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] refCrc(input logic [39:0] hdr);
    logic [6:0] c = '0;
    for (int i = 39; i >= 0; i--) begin
      logic msb = c[6];
      c = {c[5:0], 1'b0};
      if (msb ^ hdr[i]) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [47:0] refFrame(input logic [5:0] ix, input logic [31:0] ag);
    logic [39:0] hdr = {2'b01, ix, ag};
    return {hdr, refCrc(hdr), 1'b1};
  endfunction

  // Sends one frame and checks every cycle of it; intrudeAt >= 0 pulses a
  // second strobe with another index at that cycle of the frame.
  task automatic runFrame(input logic [5:0] ix, input logic [31:0] ag,
                          input int intrudeAt, output logic [47:0] got);
    int clkErr = 0, oeErr = 0, busyErr = 0, holdErr = 0;
    logic [47:0] exp = refFrame(ix, ag);
    @(negedge clk);
    idx = ix; arg = ag; start = 1'b1;
    for (int k = 0; k < 96 * P; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (k == intrudeAt) begin
        idx = ~ix; arg = ~ag; start = 1'b1;
      end
      if (sdClk !== ((k % (2 * P)) >= P)) clkErr++;
      if (cmdOe !== 1'b1) oeErr++;
      if (busy !== 1'b1) busyErr++;
      if ((k % (2 * P)) == 0) got[47 - k / (2 * P)] = cmdData;
      else if (cmdData !== got[47 - k / (2 * P)]) holdErr++;
    end
    start = 1'b0;
    check(clkErr == 0, "R5 clock phases", 64'(clkErr), 0);
    check(holdErr == 0, "R5 data stable within bit", 64'(holdErr), 0);
    check(oeErr == 0, "R6 oe during frame", 64'(oeErr), 0);
    check(busyErr == 0, "R7 busy during frame", 64'(busyErr), 0);
    check(got[47:40] === exp[47:40], "R2 start/dir/index", 64'(got[47:40]), 64'(exp[47:40]));
    check(got[39:8] === exp[39:8], "R3 argument", 64'(got[39:8]), 64'(exp[39:8]));
    check(got[7:0] === exp[7:0], "R4 crc and end bit", 64'(got[7:0]), 64'(exp[7:0]));
    @(negedge clk);
    check(!cmdOe && !busy, "R6 R7 release after end bit", {62'd0, cmdOe, busy}, 0);
    check(cmdData === 1'b1 && sdClk === 1'b0, "R1 idle levels", {62'd0, cmdData, sdClk}, 64'h2);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(!busy && !cmdOe && !sdClk && cmdData === 1'b1, "R1 reset state",
          {60'd0, busy, cmdOe, sdClk, cmdData}, 64'h1);
  endtask

  task automatic testKnown();
    logic [47:0] f;
    runFrame(6'd0, 32'h0, -1, f);
    check(f[7:0] === 8'h95, "R4 index 0 crc byte", 64'(f[7:0]), 64'h95);
    runFrame(6'd8, 32'h0000_01AA, -1, f);
    check(f[7:0] === 8'h87, "R4 index 8 crc byte", 64'(f[7:0]), 64'h87);
  endtask

  task automatic testPatterns();
    logic [47:0] f;
    runFrame(6'd63, 32'hFFFF_FFFF, -1, f);
    runFrame(6'd41, 32'hC0FF_0000, -1, f);
    runFrame(6'd17, 32'h1234_5678, -1, f);
  endtask

  task automatic testIgnore();
    logic [47:0] f;
    int extra = 0;
    runFrame(6'd55, 32'hA5A5_0F0F, 37, f);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (busy || cmdOe || sdClk) extra++;
    end
    check(extra == 0, "R8 strobe while busy not queued", 64'(extra), 0);
  endtask

  initial begin
    #(200000 * 4);
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testKnown();
    testPatterns();
    testIgnore();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule